// File: doc/BRIEF.md
# Receive D-PHY Control Register Bank

This block is a small bank of 32-bit control registers on a single-cycle memory-mapped port (valid, write, address, write data, read data). It drives the static control pins of a four-lane camera D-PHY receiver and of its companion lanes. Those pins are the lane enables, the force modes, the turnaround controls, the clock-invert selects and the test-interface pins. It also returns the receiver's 8-bit test output through one read-only status word.

Every write is a masked write. The upper half of the write word is a per-bit enable for the lower half. Software can change one field, or one test pin, without reading the register first. Bits of a register that are not implemented always read 0 and never change. Reads are combinational: the read data belongs to the address presented in the same cycle. A write takes effect at the next rising clock edge.

Top module: `dphy_rx_ctl_bank`

## Requirements
- R1: On a write to a control register, low-half bit i takes bus_wdata[i] only when bus_wdata[i+16] is 1; otherwise it keeps its value.
- R2: The receive-lane register at byte offset 0x6254 implements all 16 bits: lane enable [3:0] to rx_lane_en, force-receive [7:4] to rx_force_rx, force-stop [11:8] to rx_force_stop, turn-disable [15:12] to rx_turn_dis.
- R3: The test register at 0x6264 implements bits [10:0]: test data [7:0] to test_din, bit 8 to test_en, bit 9 to test_clk, bit 10 to test_clr; bits [15:11] read 0.
- R4: The register at 0x6224 implements bits [3:0] as rx_turn_req and bits 10 and 11 as clk_inv_sel[0] and clk_inv_sel[1]; its other bits read 0.
- R5: The companion registers at 0x6258 and 0x625c implement 16 bits, driven on aux_ctl0 and aux_ctl1; the register at 0x6260 implements bits [7:0], driven on aux_ctl2, and its upper bits read 0.
- R6: A read of a control register returns 0 in bits [31:16] and the stored value in bits [15:0].
- R7: A read of offset 0xe2a4 returns test_dout in bits [7:0] and 0 above; writes to it change nothing.
- R8: Writes to unmapped offsets change nothing, and reads of unmapped offsets return 0.
- R9: With rst_n low at a rising edge, every control bit becomes 0.
- R10: Nothing is written unless bus_valid and bus_write are both 1. bus_rdata is 0 whenever the cycle is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset |
| bus_wdata | input | 32 | Enable mask [31:16], data [15:0] |
| bus_rdata | output | 32 | Read data, same cycle |
| test_dout | input | 8 | Test output byte from the PHY |
| rx_lane_en | output | 4 | Receive lane enables |
| rx_force_rx | output | 4 | Force receive mode per lane |
| rx_force_stop | output | 4 | Force stop state per lane |
| rx_turn_dis | output | 4 | Turnaround disable per lane |
| rx_turn_req | output | 4 | Turnaround request per lane |
| clk_inv_sel | output | 2 | Clock-invert selects |
| aux_ctl0 | output | 16 | First companion-lane control word |
| aux_ctl1 | output | 16 | Second companion-lane control word |
| aux_ctl2 | output | 8 | Third companion-lane control byte |
| test_din | output | 8 | Test data input |
| test_en | output | 1 | Test enable |
| test_clk | output | 1 | Test clock level |
| test_clr | output | 1 | Test clear |

## Verification
The bench runs long pseudo-random sequences of masked writes to every control register. After each write it compares every register and every output pin with a model kept in the bench. A merge that ignored the mask would flip bits that software meant to keep. A merge that used the wrong half as the mask would corrupt other fields. Unimplemented bits are written with ones, because a bank that stored them would read them back nonzero. Writes to the status word, to unmapped offsets and with valid low are each followed by a full readback, and a decoder that aliased addresses would show changed registers there. All 256 test-output values are read through the status word. A reset in the middle of the run must clear every pin.

// File: rtl/dphy_ctl_pkg.sv
package dphy_ctl_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int NUM_CTL = 6;

  // Per-bit masked merge: enable bits in the upper half select the new data.
  function automatic logic [HALF_W-1:0] masked_merge(
      input logic [HALF_W-1:0] cur,
      input logic [WORD_W-1:0] wd,
      input logic [HALF_W-1:0] impl);
    logic [HALF_W-1:0] en;
    en = wd[WORD_W-1:HALF_W];
    return ((cur & ~en) | (wd[HALF_W-1:0] & en)) & impl;
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int ADDR_W = 16,
  parameter int N = 6,
  parameter logic [N*ADDR_W-1:0] OFFS = '0,
  parameter logic [ADDR_W-1:0] STAT_OFF = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      ctl_hit,
  output logic              stat_hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign ctl_hit[i] = (addr == OFFS[i*ADDR_W +: ADDR_W]);
  end
  assign stat_hit = (addr == STAT_OFF);

  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_hit, stat_hit})) else $error("decode overlap"); // R8
endmodule

// File: rtl/cfg_masked_reg.sv
module cfg_masked_reg
  import dphy_ctl_pkg::*;
#(
  parameter logic [HALF_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [HALF_W-1:0] q
);
  logic [HALF_W-1:0] nxt;
  logic [HALF_W-1:0] wr_mask;

  assign wr_mask = wdata[WORD_W-1:HALF_W];
  assign nxt = masked_merge(q, wdata, IMPL);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= nxt;
  end

  AST_MASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~$past(wr_mask)) == '0)) else $error("unmasked bit changed"); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)) else $error("register changed without write"); // R10
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & ~IMPL) == '0)) else $error("unimplemented bit set"); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == '0)) else $error("reset did not clear"); // R9
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import dphy_ctl_pkg::*;
#(
  parameter int N = 6,
  parameter int STAT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd,
  input  logic [N-1:0]        ctl_hit,
  input  logic                stat_hit,
  input  logic [N*HALF_W-1:0] regs,
  input  logic [STAT_W-1:0]   status,
  output logic [WORD_W-1:0]   rdata
);
  logic [WORD_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++)
      if (ctl_hit[i]) acc = acc | {{HALF_W{1'b0}}, regs[i*HALF_W +: HALF_W]};
    if (stat_hit) acc = acc | {{(WORD_W-STAT_W){1'b0}}, status};
  end

  assign rdata = rd ? acc : '0;

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !(|ctl_hit) && !stat_hit) |-> (rdata == '0)) else $error("unmapped read nonzero"); // R8
  AST_UPPER_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctl_hit) |-> (rdata[WORD_W-1:HALF_W] == '0)) else $error("upper half nonzero"); // R6
endmodule

// File: rtl/dphy_rx_ctl_bank.sv
module dphy_rx_ctl_bank
  import dphy_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STAT_W = 8,
  parameter logic [NUM_CTL*ADDR_W-1:0] CTL_OFFS =
    {16'h6264, 16'h6260, 16'h625c, 16'h6258, 16'h6254, 16'h6224},
  parameter logic [NUM_CTL*HALF_W-1:0] CTL_IMPL =
    {16'h07ff, 16'h00ff, 16'hffff, 16'hffff, 16'hffff, 16'h0c0f},
  parameter logic [ADDR_W-1:0] STAT_OFF = 16'he2a4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [STAT_W-1:0] test_dout,
  output logic [3:0]        rx_lane_en,
  output logic [3:0]        rx_force_rx,
  output logic [3:0]        rx_force_stop,
  output logic [3:0]        rx_turn_dis,
  output logic [3:0]        rx_turn_req,
  output logic [1:0]        clk_inv_sel,
  output logic [15:0]       aux_ctl0,
  output logic [15:0]       aux_ctl1,
  output logic [7:0]        aux_ctl2,
  output logic [7:0]        test_din,
  output logic              test_en,
  output logic              test_clk,
  output logic              test_clr
);
  localparam int IDX_MISC = 0;
  localparam int IDX_RX   = 1;
  localparam int IDX_AUX0 = 2;
  localparam int IDX_AUX1 = 3;
  localparam int IDX_AUX2 = 4;
  localparam int IDX_TEST = 5;

  logic [NUM_CTL-1:0]        ctl_hit;
  logic                      stat_hit;
  logic                      wr_stb;
  logic                      rd_stb;
  logic [NUM_CTL*HALF_W-1:0] ctl_flat;
  logic [HALF_W-1:0]         w_misc, w_rx, w_aux0, w_aux1, w_aux2, w_test;

  assign wr_stb = bus_valid & bus_write;
  assign rd_stb = bus_valid & ~bus_write;

  cfg_addr_decode #(
    .ADDR_W(ADDR_W), .N(NUM_CTL), .OFFS(CTL_OFFS), .STAT_OFF(STAT_OFF)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .ctl_hit(ctl_hit), .stat_hit(stat_hit)
  );

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_reg
    cfg_masked_reg #(.IMPL(CTL_IMPL[i*HALF_W +: HALF_W])) u_reg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_stb & ctl_hit[i]),
      .wdata(bus_wdata),
      .q(ctl_flat[i*HALF_W +: HALF_W])
    );
  end

  cfg_read_mux #(.N(NUM_CTL), .STAT_W(STAT_W)) u_rmux (
    .clk(clk), .rst_n(rst_n), .rd(rd_stb),
    .ctl_hit(ctl_hit), .stat_hit(stat_hit),
    .regs(ctl_flat), .status(test_dout), .rdata(bus_rdata)
  );

  assign w_misc = ctl_flat[IDX_MISC*HALF_W +: HALF_W];
  assign w_rx   = ctl_flat[IDX_RX*HALF_W   +: HALF_W];
  assign w_aux0 = ctl_flat[IDX_AUX0*HALF_W +: HALF_W];
  assign w_aux1 = ctl_flat[IDX_AUX1*HALF_W +: HALF_W];
  assign w_aux2 = ctl_flat[IDX_AUX2*HALF_W +: HALF_W];
  assign w_test = ctl_flat[IDX_TEST*HALF_W +: HALF_W];

  assign rx_lane_en    = w_rx[3:0];
  assign rx_force_rx   = w_rx[7:4];
  assign rx_force_stop = w_rx[11:8];
  assign rx_turn_dis   = w_rx[15:12];
  assign rx_turn_req   = w_misc[3:0];
  assign clk_inv_sel   = w_misc[11:10];
  assign aux_ctl0      = w_aux0;
  assign aux_ctl1      = w_aux1;
  assign aux_ctl2      = w_aux2[7:0];
  assign test_din      = w_test[7:0];
  assign test_en       = w_test[8];
  assign test_clk      = w_test[9];
  assign test_clr      = w_test[10];

  AST_NONCTL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !(|ctl_hit)) |=> $stable(ctl_flat)) else $error("stray write took effect"); // R7
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && stat_hit) |-> (bus_rdata == {{(WORD_W-STAT_W){1'b0}}, test_dout})) else $error("status readback"); // R7
  AST_NO_READ_DATA_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> (bus_rdata == '0)) else $error("rdata outside read"); // R10
endmodule

// File: tb/dphy_rx_ctl_bank_tb.sv
module dphy_rx_ctl_bank_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [15:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] test_dout = 0;
  logic [3:0] rx_lane_en, rx_force_rx, rx_force_stop, rx_turn_dis, rx_turn_req;
  logic [1:0] clk_inv_sel;
  logic [15:0] aux_ctl0, aux_ctl1;
  logic [7:0] aux_ctl2, test_din;
  logic test_en, test_clk, test_clr;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [15:0] offs [6] = '{16'h6224, 16'h6254, 16'h6258, 16'h625c, 16'h6260, 16'h6264};
  logic [15:0] impl [6] = '{16'h0c0f, 16'hffff, 16'hffff, 16'hffff, 16'h00ff, 16'h07ff};
  logic [15:0] model [6];

  always #(CLK_P/2) clk = ~clk;

  dphy_rx_ctl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .test_dout(test_dout), .rx_lane_en(rx_lane_en), .rx_force_rx(rx_force_rx),
    .rx_force_stop(rx_force_stop), .rx_turn_dis(rx_turn_dis), .rx_turn_req(rx_turn_req),
    .clk_inv_sel(clk_inv_sel), .aux_ctl0(aux_ctl0), .aux_ctl1(aux_ctl1),
    .aux_ctl2(aux_ctl2), .test_din(test_din), .test_en(test_en),
    .test_clk(test_clk), .test_clr(test_clr)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d, input logic v);
    @(negedge clk);
    bus_valid = v; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_wdata = 0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  // Bench-side model of the masked merge, written as a per-bit loop.
  task automatic model_write(input int idx, input logic [31:0] d);
    for (int b = 0; b < 16; b++)
      if (d[b+16] && impl[idx][b]) model[idx][b] = d[b];
  endtask

  task automatic check_all(input string tag);
    logic [31:0] r;
    for (int k = 0; k < 6; k++) begin
      bus_rd(offs[k], r);
      check({tag, " R6 readback"}, r, {16'h0, model[k]});
    end
    check({tag, " R2 lane_en"}, {28'h0, rx_lane_en}, {28'h0, model[1][3:0]});
    check({tag, " R2 force_rx"}, {28'h0, rx_force_rx}, {28'h0, model[1][7:4]});
    check({tag, " R2 force_stop"}, {28'h0, rx_force_stop}, {28'h0, model[1][11:8]});
    check({tag, " R2 turn_dis"}, {28'h0, rx_turn_dis}, {28'h0, model[1][15:12]});
    check({tag, " R4 turn_req"}, {28'h0, rx_turn_req}, {28'h0, model[0][3:0]});
    check({tag, " R4 clk_inv"}, {30'h0, clk_inv_sel}, {30'h0, model[0][11:10]});
    check({tag, " R5 aux0"}, {16'h0, aux_ctl0}, {16'h0, model[2]});
    check({tag, " R5 aux1"}, {16'h0, aux_ctl1}, {16'h0, model[3]});
    check({tag, " R5 aux2"}, {24'h0, aux_ctl2}, {24'h0, model[4][7:0]});
    check({tag, " R3 test pins"}, {21'h0, test_clr, test_clk, test_en, test_din},
          {21'h0, model[5][10:0]});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int k = 0; k < 6; k++) model[k] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("reset R9");

    // All-ones write exposes implemented bit masks (R3, R4, R5).
    for (int k = 0; k < 6; k++) begin
      bus_wr(offs[k], 32'hffff_ffff, 1'b1);
      model_write(k, 32'hffff_ffff);
    end
    check_all("ones R3 R4 R5");

    // Zero enable mask: nothing changes (R1).
    for (int k = 0; k < 6; k++) bus_wr(offs[k], 32'h0000_0000, 1'b1);
    check_all("mask0 R1");

    // Valid low write is ignored (R10).
    for (int k = 0; k < 6; k++) bus_wr(offs[k], 32'hffff_0000, 1'b0);
    check_all("novalid R10");

    // Pseudo-random masked writes sweep (R1).
    for (int it = 0; it < 60; it++) begin
      for (int k = 0; k < 6; k++) begin
        seed = next_rand(seed);
        bus_wr(offs[k], seed, 1'b1);
        model_write(k, seed);
      end
      check_all("sweep R1");
    end

    // Single-bit test clock toggles through the mask (R1, R3).
    bus_wr(16'h6264, 32'h0200_0000, 1'b1); model_write(5, 32'h0200_0000);
    check({"R3 test_clk low"}, {31'h0, test_clk}, 32'h0);
    bus_wr(16'h6264, 32'h0200_0200, 1'b1); model_write(5, 32'h0200_0200);
    check({"R3 test_clk high"}, {31'h0, test_clk}, 32'h1);
    check_all("tclk R3");

    // Writes to status and unmapped offsets change nothing (R7, R8).
    bus_wr(16'he2a4, 32'hffff_ffff, 1'b1);
    bus_wr(16'h0000, 32'hffff_ffff, 1'b1);
    bus_wr(16'h6225, 32'hffff_a5a5, 1'b1);
    bus_wr(16'h6268, 32'hffff_5a5a, 1'b1);
    bus_wr(16'he2a0, 32'hffff_ffff, 1'b1);
    check_all("stray R7 R8");
    bus_rd(16'h6268, r); check("R8 unmapped read", r, 32'h0);
    bus_rd(16'h0000, r); check("R8 unmapped read 0", r, 32'h0);
    bus_rd(16'h6226, r); check("R8 unaligned read", r, 32'h0);

    // Status sweep over every test output value (R7).
    for (int v = 0; v < 256; v++) begin
      test_dout = v[7:0];
      bus_rd(16'he2a4, r);
      check("R7 status", r, {24'h0, v[7:0]});
    end

    // No read data during writes or idle cycles (R10).
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 16'he2a4; bus_wdata = 32'h0;
    #1 check("R10 rdata on write", bus_rdata, 32'h0);
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_addr = 16'h6254;
    #1 check("R10 rdata idle", bus_rdata, 32'h0);

    // Mid-run reset clears everything (R9).
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < 6; k++) model[k] = 16'h0;
    check_all("midreset R9");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule